// File: doc/BRIEF.md
# Register-Mapped Event Counter Group

This block holds a small bank of event counters that software reaches through a plain address / write-data / read-data register port. Each counter has its own event-code register and stream-pattern register. It counts pulses on its own bit of an event input vector when the stream identifier that comes with the pulse passes the counter's stream filter. Event code 0 counts clock cycles instead. Software can write any counter value, for example to preload it to half of full scale. When a counter wraps from all ones to zero, its overflow flag is set. A level interrupt reports overflow flags that software has chosen to see.

The counter enables, the interrupt enables and the overflow flags are bit vectors. Writing ones to one address sets bits, and writing ones to a second address clears them, so software never has to do a read-modify-write. An elaboration-time option puts the group in shared-filter mode. In that mode the span and pattern of counter 0 qualify the events of every counter, and the other counters use only their event code.

Top module: `evt_counter_group`

## Requirements
- R1: After reset every counter is zero and all vectors and both global switches are off. Each event register reads 0x20000000 (code 0, span bit 29 set) and each pattern register reads all ones over SID_W bits. The read-only word at 0xE00 holds counters-1 in bits 5:0, width-1 in bits 13:8, and the shared-filter option in bit 23. Bits 21 and 20 read zero.
- R2: Counter n starts at 4*n when CTR_W <= 32. Otherwise it starts at 8*n, with bits 31:0 at that address and the upper bits at +4. Writes load the counter and reads return it. Event registers are at 0x400+4*n and pattern registers at 0xA00+4*n.
- R3: A counter advances by one on a clock edge only when all of these hold: the global count switch (0xE04 bit 0) is 1, its enable bit is 1 (ones written to 0xC00 set enables, ones written to 0xC20 clear them), its event input is 1, and the filter passes.
- R4: Event code 0 advances the counter on every enabled cycle, whatever the event input and stream are.
- R5: A code that is not set in the 128-bit supported mask stops the counter, for example 0xFFFF or 8 under the default mask of codes 0 to 7. The mask reads as four words at 0xE20, 0xE24, 0xE28 and 0xE2C, lowest word first.
- R6: With the span bit (event register bit 29) at 0, only a stream equal to the pattern passes.
- R7: With the span bit at 1, the lowest zero bit of the pattern and every bit below it are don't-care. All bits above it must match. Pattern 0x42 passes 0x42 and 0x43 only, and an all-ones pattern passes every stream.
- R8: In shared-filter mode, counter 0's span and pattern decide for every counter. The other counters' own span and pattern have no effect.
- R9: A wrap from all ones to zero sets that counter's overflow flag, which reads at 0xCC0 and 0xC80. A software load never sets a flag. Ones written to 0xC80 clear flags.
- R10: The irq output is 1 exactly when the interrupt switch (0xE50 bit 0) is 1 and a flag is set whose interrupt enable is set. Ones written to 0xC40 set interrupt enables and ones written to 0xC60 clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 12 | Register byte address |
| regWrEn | input | 1 | Write strobe for regAddr |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, same cycle |
| evtIn | input | NUM_CTR | One event pulse per counter |
| streamId | input | SID_W | Stream of the current events |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench aims at the boundaries of the counting condition. It shows that any one missing term (global switch, own enable, event, filter) keeps the counter still. A design that dropped one of them would count when it should not. The span filter is driven with neighbour streams on both sides of the pattern. A wrong don't-care mask would admit 0x40 or 0x44, or reject 0x43. A wide counter is preloaded one step below the wrap and stepped across it. This catches a flag that is raised by the software load or is missing at the wrap, and a swapped upper half. Shared-filter mode is tested by leaving counter 1 with a permissive filter of its own. If the design used the counter's own filter, the counter would advance on a stream that counter 0 rejects.

// File: rtl/evcg_pkg.sv
package evcg_pkg;

  localparam int MAX_CTR = 32;
  localparam int SPAN_POS = 29;

  typedef struct packed {
    logic [MAX_CTR-1:0] ctrLo;
    logic [MAX_CTR-1:0] ctrHi;
    logic [MAX_CTR-1:0] evtType;
    logic [MAX_CTR-1:0] match;
    logic enSet;
    logic enClr;
    logic intSet;
    logic intClr;
    logic ovsClr;
    logic ctlWr;
    logic irqWr;
    logic [31:0] data;
  } wrStrb_t;

  typedef enum logic [3:0] {
    RD_ZERO, RD_CTRLO, RD_CTRHI, RD_TYPE, RD_MATCH, RD_EN, RD_INTEN,
    RD_OVS, RD_CFG, RD_CTL, RD_IRQCTL, RD_SUP
  } rdKind_t;

  typedef struct packed {
    rdKind_t kind;
    logic [4:0] idx;
  } rdSel_t;

endpackage

// File: rtl/evcg_ctrl.sv
module evcg_ctrl
  import evcg_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W = 40
) (
  input  logic [11:0] regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output wrStrb_t     strb,
  output rdSel_t      rdSel
);

  localparam bit WIDE = (CTR_W > 32);

  logic [9:0] ctrIdx;
  logic       hiHalf;
  logic [5:0] regIdx;

  assign ctrIdx = WIDE ? {1'b0, regAddr[11:3]} : regAddr[11:2];
  assign hiHalf = WIDE && regAddr[2];
  assign regIdx = regAddr[7:2];

  always_comb begin
    strb = '0;
    strb.data = regWrData;
    rdSel.kind = RD_ZERO;
    rdSel.idx = '0;
    if (regAddr < 12'h400) begin
      if (ctrIdx < 10'(NUM_CTR)) begin
        rdSel.idx = ctrIdx[4:0];
        if (hiHalf) begin
          rdSel.kind = RD_CTRHI;
          strb.ctrHi[ctrIdx[4:0]] = regWrEn;
        end else begin
          rdSel.kind = RD_CTRLO;
          strb.ctrLo[ctrIdx[4:0]] = regWrEn;
        end
      end
    end else if (regAddr[11:8] == 4'h4) begin
      if (regIdx < 6'(NUM_CTR)) begin
        rdSel.kind = RD_TYPE;
        rdSel.idx = regIdx[4:0];
        strb.evtType[regIdx[4:0]] = regWrEn;
      end
    end else if (regAddr[11:8] == 4'hA) begin
      if (regIdx < 6'(NUM_CTR)) begin
        rdSel.kind = RD_MATCH;
        rdSel.idx = regIdx[4:0];
        strb.match[regIdx[4:0]] = regWrEn;
      end
    end else begin
      case (regAddr)
        12'hC00: begin rdSel.kind = RD_EN;    strb.enSet  = regWrEn; end
        12'hC20: begin rdSel.kind = RD_EN;    strb.enClr  = regWrEn; end
        12'hC40: begin rdSel.kind = RD_INTEN; strb.intSet = regWrEn; end
        12'hC60: begin rdSel.kind = RD_INTEN; strb.intClr = regWrEn; end
        12'hC80: begin rdSel.kind = RD_OVS;   strb.ovsClr = regWrEn; end
        12'hCC0: rdSel.kind = RD_OVS;
        12'hE00: rdSel.kind = RD_CFG;
        12'hE04: begin rdSel.kind = RD_CTL;    strb.ctlWr = regWrEn; end
        12'hE50: begin rdSel.kind = RD_IRQCTL; strb.irqWr = regWrEn; end
        12'hE20, 12'hE24, 12'hE28, 12'hE2C: begin
          rdSel.kind = RD_SUP;
          rdSel.idx = {3'b000, regAddr[3:2]};
        end
        default: rdSel.kind = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/evcg_dp.sv
module evcg_dp
  import evcg_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W = 40,
  parameter int SID_W = 16,
  parameter bit GLOBAL_FILT = 1'b0,
  parameter logic [127:0] EVT_SUPPORT = 128'hFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  wrStrb_t            strb,
  input  rdSel_t             rdSel,
  input  logic [NUM_CTR-1:0] evtIn,
  input  logic [SID_W-1:0]   streamId,
  output logic [31:0]        rdData,
  output logic               irq,
  output logic               ctlOn,
  output logic               irqOn,
  output logic [NUM_CTR-1:0] cntEn,
  output logic [NUM_CTR-1:0] intEn,
  output logic [NUM_CTR-1:0] ovs,
  output logic [CTR_W-1:0]   ctrFirst
);

  localparam int IW = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
  localparam logic [31:0] CFG_WORD = {8'h00, GLOBAL_FILT, 2'b00, 1'b0, 6'h00,
                                      6'(CTR_W - 1), 2'b00, 6'(NUM_CTR - 1)};

  logic [CTR_W-1:0] ctr [NUM_CTR];
  logic [15:0]      code [NUM_CTR];
  logic             span [NUM_CTR];
  logic [SID_W-1:0] smr [NUM_CTR];
  logic [NUM_CTR-1:0] inc, wrap;

  function automatic logic sidHit(input logic spanMode, input logic [SID_W-1:0] pat,
                                  input logic [SID_W-1:0] sid);
    logic [SID_W-1:0] care;
    care = spanMode ? ~(pat ^ (pat + 1'b1)) : '1;
    return ((sid ^ pat) & care) == '0;
  endfunction

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    localparam int FSRC = GLOBAL_FILT ? 0 : i;
    logic supported, qualified;
    logic [CTR_W-1:0] wrVal;

    assign supported = (code[i][15:7] == '0) && EVT_SUPPORT[code[i][6:0]];
    assign qualified = (code[i] == 16'h0000) ||
                       (evtIn[i] && sidHit(span[FSRC], smr[FSRC], streamId));
    assign inc[i] = ctlOn && cntEn[i] && supported && qualified;
    assign wrap[i] = inc[i] && (&ctr[i]) && !strb.ctrLo[i] && !strb.ctrHi[i];

    if (CTR_W > 32) begin : g_wide
      always_comb begin
        wrVal = ctr[i];
        if (strb.ctrLo[i]) wrVal[31:0] = strb.data;
        if (strb.ctrHi[i]) wrVal[CTR_W-1:32] = strb.data[CTR_W-33:0];
      end
    end else begin : g_narrow
      assign wrVal = strb.data[CTR_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctr[i]  <= '0;
        code[i] <= 16'h0000;
        span[i] <= 1'b1;
        smr[i]  <= '1;
      end else begin
        if (strb.ctrLo[i] || strb.ctrHi[i]) ctr[i] <= wrVal;
        else if (inc[i]) ctr[i] <= ctr[i] + 1'b1;
        if (strb.evtType[i]) begin
          code[i] <= strb.data[15:0];
          span[i] <= strb.data[SPAN_POS];
        end
        if (strb.match[i]) smr[i] <= strb.data[SID_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntEn <= '0;
      intEn <= '0;
      ovs   <= '0;
      ctlOn <= 1'b0;
      irqOn <= 1'b0;
    end else begin
      if (strb.enSet) cntEn <= cntEn | strb.data[NUM_CTR-1:0];
      else if (strb.enClr) cntEn <= cntEn & ~strb.data[NUM_CTR-1:0];
      if (strb.intSet) intEn <= intEn | strb.data[NUM_CTR-1:0];
      else if (strb.intClr) intEn <= intEn & ~strb.data[NUM_CTR-1:0];
      ovs <= (strb.ovsClr ? (ovs & ~strb.data[NUM_CTR-1:0]) : ovs) | wrap;
      if (strb.ctlWr) ctlOn <= strb.data[0];
      if (strb.irqWr) irqOn <= strb.data[0];
    end
  end

  assign irq = irqOn && ((ovs & intEn) != '0);
  assign ctrFirst = ctr[0];

  logic [IW-1:0] rIdx;
  logic [63:0]   ctrWide;
  assign rIdx = rdSel.idx[IW-1:0];
  assign ctrWide = 64'(ctr[rIdx]);

  always_comb begin
    case (rdSel.kind)
      RD_CTRLO:   rdData = ctrWide[31:0];
      RD_CTRHI:   rdData = ctrWide[63:32];
      RD_TYPE:    rdData = {2'b00, span[rIdx], 13'h0000, code[rIdx]};
      RD_MATCH:   rdData = 32'(smr[rIdx]);
      RD_EN:      rdData = 32'(cntEn);
      RD_INTEN:   rdData = 32'(intEn);
      RD_OVS:     rdData = 32'(ovs);
      RD_CFG:     rdData = CFG_WORD;
      RD_CTL:     rdData = {31'h0, ctlOn};
      RD_IRQCTL:  rdData = {31'h0, irqOn};
      RD_SUP:     rdData = EVT_SUPPORT[{rdSel.idx[1:0], 5'b00000} +: 32];
      default:    rdData = 32'h0;
    endcase
  end

endmodule

// File: rtl/evt_counter_group.sv
module evt_counter_group
  import evcg_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W = 40,
  parameter int SID_W = 16,
  parameter bit GLOBAL_FILT = 1'b0,
  parameter logic [127:0] EVT_SUPPORT = 128'hFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [11:0]        regAddr,
  input  logic               regWrEn,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [NUM_CTR-1:0] evtIn,
  input  logic [SID_W-1:0]   streamId,
  output logic               irq
);

  wrStrb_t strb;
  rdSel_t  rdSel;
  logic ctlOn, irqOn;
  logic [NUM_CTR-1:0] cntEn, intEn, ovs;
  logic [CTR_W-1:0] ctrFirst;

  evcg_ctrl #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .strb(strb), .rdSel(rdSel)
  );

  evcg_dp #(
    .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .SID_W(SID_W),
    .GLOBAL_FILT(GLOBAL_FILT), .EVT_SUPPORT(EVT_SUPPORT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .evtIn(evtIn),
    .streamId(streamId), .rdData(regRdData), .irq(irq), .ctlOn(ctlOn),
    .irqOn(irqOn), .cntEn(cntEn), .intEn(intEn), .ovs(ovs), .ctrFirst(ctrFirst)
  );

endmodule

// File: rtl/evcg_checker.sv
module evcg_checker #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W = 40
) (
  input logic               clk,
  input logic               rstN,
  input logic               ctrWr0,
  input logic               ovsClr0,
  input logic               ctlOn,
  input logic               irqOn,
  input logic [NUM_CTR-1:0] cntEn,
  input logic [NUM_CTR-1:0] intEn,
  input logic [NUM_CTR-1:0] ovs,
  input logic [CTR_W-1:0]   ctrFirst,
  input logic               irq
);

  a_r3_hold_global_off: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlOn && !ctrWr0) |=> $stable(ctrFirst));

  a_r3_hold_own_off: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn[0] && !ctrWr0) |=> $stable(ctrFirst));

  a_r9_flag_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovs[0]) |-> (ctrFirst == '0));

  a_r9_flag_drop_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovs[0]) |-> $past(ovsClr0));

  a_r10_irq_off_when_masked: assert property (@(posedge clk) disable iff (!rstN)
    !irqOn |-> !irq);

  a_r10_irq_needs_source: assert property (@(posedge clk) disable iff (!rstN)
    ((ovs & intEn) == '0) |-> !irq);

endmodule

bind evt_counter_group evcg_checker #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .ctrWr0(strb.ctrLo[0] | strb.ctrHi[0]),
  .ovsClr0(strb.ovsClr & strb.data[0]),
  .ctlOn(ctlOn), .irqOn(irqOn), .cntEn(cntEn), .intEn(intEn), .ovs(ovs),
  .ctrFirst(ctrFirst), .irq(irq)
);

// File: tb/sim_evt_counter_group.sv
module sim_evt_counter_group;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic we0 = 1'b0, we1 = 1'b0;
  logic [31:0] rd0, rd1;
  logic [3:0] evt0 = '0;
  logic [1:0] evt1 = '0;
  logic [15:0] sid = '0;
  logic irq0, irq1;
  int nChk = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  evt_counter_group u0 (
    .clk(clk), .rstN(rstN), .regAddr(addr), .regWrEn(we0), .regWrData(wdata),
    .regRdData(rd0), .evtIn(evt0), .streamId(sid), .irq(irq0)
  );

  evt_counter_group #(.NUM_CTR(2), .CTR_W(16), .SID_W(16), .GLOBAL_FILT(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .regAddr(addr), .regWrEn(we1), .regWrData(wdata),
    .regRdData(rd1), .evtIn(evt1), .streamId(sid), .irq(irq1)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [11:0] a, input logic [31:0] d);
    addr = a;
    wdata = d;
    if (sel) we1 = 1'b1; else we0 = 1'b1;
    @(negedge clk);
    we0 = 1'b0;
    we1 = 1'b0;
  endtask

  task automatic rd(input bit sel, input logic [11:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = sel ? rd1 : rd0;
  endtask

  task automatic rdCtr(input int n, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(0, 12'(n * 8), lo);
    rd(0, 12'(n * 8 + 4), hi);
    v = {hi, lo};
  endtask

  task automatic stepEvt(input int n, input int cycles);
    evt0[n] = 1'b1;
    repeat (cycles) @(negedge clk);
    evt0[n] = 1'b0;
  endtask

  task automatic tReset();
    logic [31:0] v;
    rd(0, 12'hE00, v); chk("R1 cfg u0", v, 32'h0000_2703);
    rd(1, 12'hE00, v); chk("R1 cfg u1", v, 32'h0080_0F01);
    rd(0, 12'h404, v); chk("R1 evtype reset", v, 32'h2000_0000);
    rd(0, 12'hA08, v); chk("R1 pattern reset", v, 32'h0000_FFFF);
    rd(0, 12'h010, v); chk("R1 counter reset", v, 0);
    rd(0, 12'hCC0, v); chk("R1 overflow reset", v, 0);
    chk("R1 irq reset", irq0, 0);
    @(negedge clk);
  endtask

  task automatic tSupported();
    logic [31:0] v;
    rd(0, 12'hE20, v); chk("R5 mask word0", v, 32'hFF);
    rd(0, 12'hE24, v); chk("R5 mask word1", v, 0);
    @(negedge clk);
  endtask

  task automatic tLayout();
    logic [31:0] v;
    logic [63:0] c;
    wr(0, 12'h010, 32'h89AB_CDEF);
    wr(0, 12'h014, 32'h0000_0012);
    rdCtr(2, c); chk("R2 wide preload", c, 64'h12_89AB_CDEF);
    rd(0, 12'h008, v); chk("R2 neighbour untouched", v, 0);
    @(negedge clk);
    wr(1, 12'h004, 32'h0000_BEEF);
    rd(1, 12'h004, v); chk("R2 narrow stride", v, 32'hBEEF);
    rd(1, 12'h000, v); chk("R2 narrow ctr0", v, 0);
    @(negedge clk);
  endtask

  task automatic tGating();
    logic [63:0] c;
    wr(0, 12'h400, 32'h2000_0001);
    wr(0, 12'hC00, 32'h1);
    stepEvt(0, 5);
    rdCtr(0, c); chk("R3 global off holds", c, 0);
    @(negedge clk);
    wr(0, 12'hE04, 32'h1);
    stepEvt(0, 6);
    rdCtr(0, c); chk("R3 counts events", c, 6);
    @(negedge clk);
    repeat (3) @(negedge clk);
    rdCtr(0, c); chk("R3 no event no count", c, 6);
    @(negedge clk);
    wr(0, 12'hC20, 32'h1);
    stepEvt(0, 4);
    rdCtr(0, c); chk("R3 own enable off holds", c, 6);
    @(negedge clk);
  endtask

  task automatic tCycles();
    logic [31:0] a, b;
    sid = 16'h1234;
    wr(0, 12'hC00, 32'h2);
    rd(0, 12'h008, a);
    repeat (7) @(negedge clk);
    rd(0, 12'h008, b);
    chk("R4 cycle code counts every cycle", b - a, 7);
    @(negedge clk);
    wr(0, 12'h404, 32'h0000_FFFF);
    rd(0, 12'h008, a);
    repeat (5) @(negedge clk);
    rd(0, 12'h008, b);
    chk("R5 code 0xFFFF stops counter", b - a, 0);
    @(negedge clk);
    wr(0, 12'h404, 32'h0000_0008);
    rd(0, 12'h008, a);
    repeat (4) @(negedge clk);
    rd(0, 12'h008, b);
    chk("R5 code 8 unsupported", b - a, 0);
    @(negedge clk);
    wr(0, 12'hC20, 32'h2);
  endtask

  task automatic tFilter();
    logic [63:0] c;
    wr(0, 12'h40C, 32'h0000_0001);
    wr(0, 12'hA0C, 32'h0000_0042);
    wr(0, 12'hC00, 32'h8);
    sid = 16'h0042; stepEvt(3, 4);
    sid = 16'h0043; stepEvt(3, 4);
    rdCtr(3, c); chk("R6 exact match", c, 4);
    @(negedge clk);
    wr(0, 12'h40C, 32'h2000_0001);
    wr(0, 12'h018, 32'h0);
    sid = 16'h0043; stepEvt(3, 3);
    sid = 16'h0040; stepEvt(3, 3);
    sid = 16'h0044; stepEvt(3, 3);
    sid = 16'h0142; stepEvt(3, 2);
    sid = 16'h0042; stepEvt(3, 2);
    rdCtr(3, c); chk("R7 span pattern", c, 5);
    @(negedge clk);
    wr(0, 12'hC20, 32'h8);
  endtask

  task automatic tWrap();
    logic [31:0] v;
    logic [63:0] c;
    wr(0, 12'h010, 32'hFFFF_FFFE);
    wr(0, 12'h014, 32'h0000_00FF);
    wr(0, 12'h408, 32'h2000_0001);
    wr(0, 12'hC00, 32'h4);
    rd(0, 12'hCC0, v); chk("R9 load sets no flag", v, 0);
    @(negedge clk);
    stepEvt(2, 1);
    rdCtr(2, c); chk("R9 one below wrap", c, 64'hFF_FFFF_FFFF);
    rd(0, 12'hCC0, v); chk("R9 no flag yet", v, 0);
    @(negedge clk);
    stepEvt(2, 1);
    rdCtr(2, c); chk("R9 wrapped to zero", c, 0);
    rd(0, 12'hCC0, v); chk("R9 flag set", v, 32'h4);
    chk("R10 no irq without enable", irq0, 0);
    @(negedge clk);
    wr(0, 12'hC40, 32'h4);
    #1 chk("R10 no irq with switch off", irq0, 0);
    wr(0, 12'hE50, 32'h1);
    #1 chk("R10 irq raised", irq0, 1);
    wr(0, 12'hE50, 32'h0);
    #1 chk("R10 switch off drops irq", irq0, 0);
    wr(0, 12'hE50, 32'h1);
    wr(0, 12'hC60, 32'h4);
    #1 chk("R10 enable clear drops irq", irq0, 0);
    wr(0, 12'hC40, 32'h4);
    #1 chk("R10 enable set restores irq", irq0, 1);
    wr(0, 12'hC80, 32'h4);
    rd(0, 12'hCC0, v); chk("R9 flag cleared", v, 0);
    chk("R10 irq after clear", irq0, 0);
    @(negedge clk);
  endtask

  task automatic tShared();
    logic [31:0] v;
    wr(1, 12'hA00, 32'h0000_0010);
    wr(1, 12'h400, 32'h0000_0001);
    wr(1, 12'h404, 32'h2000_0001);
    wr(1, 12'h004, 32'h0);
    wr(1, 12'hC00, 32'h3);
    wr(1, 12'hE04, 32'h1);
    sid = 16'h0011;
    evt1 = 2'b11;
    repeat (3) @(negedge clk);
    evt1 = 2'b00;
    rd(1, 12'h004, v); chk("R8 counter1 uses counter0 filter", v, 0);
    rd(1, 12'h000, v); chk("R8 counter0 rejects", v, 0);
    @(negedge clk);
    sid = 16'h0010;
    evt1 = 2'b11;
    repeat (4) @(negedge clk);
    evt1 = 2'b00;
    rd(1, 12'h004, v); chk("R8 counter1 passes", v, 4);
    rd(1, 12'h000, v); chk("R8 counter0 passes", v, 4);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSupported();
    tLayout();
    tGating();
    tCycles();
    tFilter();
    tWrap();
    tShared();
    $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
    $finish;
  end

  initial begin
    #800000;
    nChk++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
    $finish;
  end

endmodule